// File: doc/BRIEF.md
# Scheduled Egress Guard Band Controller

This block sits beside the transmit scheduler of one Ethernet egress port and decides, once per byte-time, whether a new frame may begin. It protects a timed express frame: a frame is refused when it, together with its preamble, start delimiter, interframe gap and a configurable fill margin, would still be on the wire when the express frame is due. A second, byte-scaled margin marks the tail of a zero-allow interval. Inside that tail, preemptable traffic is refused and flagged for clearing off the wire.

The countdown of bytes to the next timed express frame and the zero-allow countdown come from outside, as does the length of the candidate frame. The block turns these into registered start permits for express and preemptable frames, a preempt-clear flag, and an idle-fill indication. The idle-fill indication tells the MAC that the wire is being held idle on purpose. Wire occupancy is counted as frame length + 8 bytes of preamble and start delimiter + 12 bytes of interframe gap.

Top module: `gb_guard_ctrl`

## Requirements
- R1: An edge with `rst_n` low drives all four outputs (`xp_start_ok`, `pe_start_ok`, `pe_clear`, `fill_idle`) to 0. After reset, fill mode is off and both margins are 0 (the caller drives the config inputs to 0 in reset).
- R2: The outputs are registered. They take new values only at an edge where `byte_tick` is 1, and they show those values from that edge on. At any other edge they hold.
- R3: With `fill_en`=1 and `port_idle`=1, `xp_start_ok` becomes 1 exactly when `frame_len + 20 + fill_margin <= bytes_to_express`. Equality permits the start, and one byte less refuses it.
- R4: With `fill_en`=0, `xp_start_ok` equals `port_idle`, whatever the express countdown.
- R5: With `port_idle`=0, both `xp_start_ok` and `pe_start_ok` become 0.
- R6: `pe_clear` becomes 1 exactly when `zero_allow_cnt <= pre_clear_margin * 8`. Equality sets it, and one byte more clears it. It does not depend on `port_idle`.
- R7: `pe_start_ok` becomes 1 exactly when `port_idle`=1, `pe_clear` would be 0, and either `fill_en`=0 or the R3 fill test passes.
- R8: `fill_idle` becomes 1 exactly when `fill_en`=1, `port_idle`=1 and the R3 fill test fails. It is never 1 together with `xp_start_ok`.
- R9: Full-range settings compare without truncation. A fill margin of 1023 with a maximum frame length of 16383, and a clear margin of 127 (1016 bytes), give exact results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_tick | input | 1 | Byte-time strobe; outputs re-evaluate on it |
| port_idle | input | 1 | Wire is free for a new frame start |
| frame_len | input | LEN_W (14) | Candidate frame length in bytes |
| bytes_to_express | input | CNT_W (16) | Bytes left until the timed express frame is due |
| zero_allow_cnt | input | CNT_W (16) | Bytes left in the current zero-allow interval |
| fill_en | input | 1 | Fill mode enable |
| fill_margin | input | FILL_W (10) | Fill margin in bytes |
| pre_clear_margin | input | PCM_W (7) | Preempt clear margin in units of 8 bytes |
| xp_start_ok | output | 1 | Express frame may start |
| pe_start_ok | output | 1 | Preemptable frame may start |
| pe_clear | output | 1 | Preemptable traffic must be cleared from the wire |
| fill_idle | output | 1 | Wire held idle by the fill rule |

## Verification
The bench builds the block with its default widths: a 16-bit countdown, 14-bit frame length, 10-bit fill margin and 7-bit clear margin. With these widths every corner is a plain input value. The bench can drive margins of 1023 and 127 together with a maximal frame. It can place the countdowns exactly on, and one byte past, each comparison threshold. It can also reach the zero-margin, zero-length cases where the 20-byte overhead alone decides.

// File: rtl/gb_pkg.sv
// Package: shared constants and the decision bundle for the guard band
// controller. Assumes byte-granular counts throughout.
package gb_pkg;
    localparam int IFG_BYTES  = 12;  // interframe gap on the wire
    localparam int PRE_BYTES  = 8;   // preamble plus start delimiter
    localparam int OVERHEAD   = IFG_BYTES + PRE_BYTES;
    localparam int PCM_SHIFT  = 3;   // clear margin unit is 8 bytes

    typedef struct packed {
        logic xp;    // express start permit
        logic pe;    // preemptable start permit
        logic clr;   // preempt clear zone
        logic fill;  // idle held by fill rule
    } gb_perm_t;
endpackage

// File: rtl/gb_fill_check.sv
// Fill check: reports whether a frame of the given length, plus overhead and
// fill margin, ends on or before the express due time. Assumes LEN_W and
// FILL_W do not exceed CNT_W; the sum is widened by two bits so it never wraps.
module gb_fill_check #(
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 14,
    parameter int FILL_W = 10
) (
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [FILL_W-1:0] fill_margin,
    input  logic [CNT_W-1:0]  bytes_to_express,
    output logic              fits
);
    import gb_pkg::*;
    localparam int SUM_W = CNT_W + 2;

    logic [SUM_W-1:0] need;

    // Total bytes the start would occupy before the express slot.
    always_comb begin
        need = SUM_W'(frame_len) + SUM_W'(OVERHEAD) + SUM_W'(fill_margin);
        fits = (need <= SUM_W'(bytes_to_express));
    end
endmodule

// File: rtl/gb_preempt_zone.sv
// Preempt zone: flags the tail of a zero-allow interval in which preemptable
// traffic must be off the wire. Assumes the margin counts 8-byte units.
module gb_preempt_zone #(
    parameter int CNT_W = 16,
    parameter int PCM_W = 7
) (
    input  logic [CNT_W-1:0] zero_allow_cnt,
    input  logic [PCM_W-1:0] pre_clear_margin,
    output logic             in_zone
);
    import gb_pkg::*;
    localparam int THR_W = PCM_W + PCM_SHIFT;
    localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

    logic [THR_W-1:0] thr;

    // Scale the margin to bytes and compare against the remaining count.
    always_comb begin
        thr     = {pre_clear_margin, {PCM_SHIFT{1'b0}}};
        in_zone = (CMP_W'(zero_allow_cnt) <= CMP_W'(thr));
    end
endmodule

// File: rtl/gb_decide.sv
// Decision: combines idle state, fill mode and both checks into the four
// next-state permit bits. Purely combinational; the top registers it.
module gb_decide (
    input  logic               port_idle,
    input  logic               fill_en,
    input  logic               fits,
    input  logic               in_zone,
    output gb_pkg::gb_perm_t   nxt
);
    logic fill_ok;

    // Fill rule only restricts starts while fill mode is on.
    always_comb begin
        fill_ok  = !fill_en || fits;
        nxt.xp   = port_idle && fill_ok;
        nxt.pe   = port_idle && fill_ok && !in_zone;
        nxt.clr  = in_zone;
        nxt.fill = port_idle && fill_en && !fits;
    end
endmodule

// File: rtl/gb_guard_ctrl.sv
// Guard band controller top: evaluates start permits once per byte-time and
// holds them between strobes. Assumes the countdowns are already aligned to
// byte_tick and that the config inputs are stable across a strobe.
module gb_guard_ctrl #(
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 14,
    parameter int FILL_W = 10,
    parameter int PCM_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_tick,
    input  logic              port_idle,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [CNT_W-1:0]  bytes_to_express,
    input  logic [CNT_W-1:0]  zero_allow_cnt,
    input  logic              fill_en,
    input  logic [FILL_W-1:0] fill_margin,
    input  logic [PCM_W-1:0]  pre_clear_margin,
    output logic              xp_start_ok,
    output logic              pe_start_ok,
    output logic              pe_clear,
    output logic              fill_idle
);
    import gb_pkg::*;

    logic     fits;
    logic     in_zone;
    gb_perm_t nxt;
    gb_perm_t q;

    gb_fill_check #(.CNT_W(CNT_W), .LEN_W(LEN_W), .FILL_W(FILL_W)) u_fill (
        .frame_len        (frame_len),
        .fill_margin      (fill_margin),
        .bytes_to_express (bytes_to_express),
        .fits             (fits)
    );

    gb_preempt_zone #(.CNT_W(CNT_W), .PCM_W(PCM_W)) u_zone (
        .zero_allow_cnt   (zero_allow_cnt),
        .pre_clear_margin (pre_clear_margin),
        .in_zone          (in_zone)
    );

    gb_decide u_dec (
        .port_idle (port_idle),
        .fill_en   (fill_en),
        .fits      (fits),
        .in_zone   (in_zone),
        .nxt       (nxt)
    );

    // Permit register: clear in reset, load on byte strobe, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)         q <= '0;
        else if (byte_tick) q <= nxt;
    end

    assign xp_start_ok = q.xp;
    assign pe_start_ok = q.pe;
    assign pe_clear    = q.clr;
    assign fill_idle   = q.fill;

    // R1: reset edge leaves all outputs low.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!xp_start_ok && !pe_start_ok && !pe_clear && !fill_idle));

    // R2: no strobe, no change.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_tick |=> $stable(q));

    // R4: fill off and idle always yields an express permit.
    a_r4_fill_off: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_tick && !fill_en && port_idle) |=> xp_start_ok);

    // R5: busy port yields no permits.
    a_r5_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_tick && !port_idle) |=> (!xp_start_ok && !pe_start_ok));

    // R7: a preemptable permit never coexists with the clear zone.
    a_r7_pe_zone: assert property (@(posedge clk) disable iff (!rst_n)
        pe_start_ok |-> !pe_clear);

    // R8: idle fill and express permit are exclusive.
    a_r8_fill_excl: assert property (@(posedge clk) disable iff (!rst_n)
        fill_idle |-> !xp_start_ok);
endmodule

// File: tb/sim_gb_guard_ctrl.sv
module sim_gb_guard_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_tick = 1'b0;
    logic        port_idle = 1'b0;
    logic [13:0] frame_len = '0;
    logic [15:0] bytes_to_express = '0;
    logic [15:0] zero_allow_cnt = '0;
    logic        fill_en = 1'b0;
    logic [9:0]  fill_margin = '0;
    logic [6:0]  pre_clear_margin = '0;
    logic        xp_start_ok, pe_start_ok, pe_clear, fill_idle;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gb_guard_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .byte_tick(byte_tick), .port_idle(port_idle),
        .frame_len(frame_len), .bytes_to_express(bytes_to_express),
        .zero_allow_cnt(zero_allow_cnt), .fill_en(fill_en),
        .fill_margin(fill_margin), .pre_clear_margin(pre_clear_margin),
        .xp_start_ok(xp_start_ok), .pe_start_ok(pe_start_ok),
        .pe_clear(pe_clear), .fill_idle(fill_idle)
    );

    typedef struct packed {
        logic        idle;
        logic        fen;
        logic [13:0] len;
        logic [15:0] btx;
        logic [9:0]  marg;
        logic [15:0] zac;
        logic [6:0]  pcm;
        logic [3:0]  exp;   // {xp, pe, clr, fill}
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        // R3 equality permits: 64+20+0 = 84
        '{1'b1, 1'b1, 14'd64,    16'd84,    10'd0,    16'd1000,  7'd0,   4'b1100},
        // R3/R8 one byte short refuses
        '{1'b1, 1'b1, 14'd64,    16'd83,    10'd0,    16'd1000,  7'd0,   4'b0001},
        // R4 fill off ignores countdown; R6 100 > 96
        '{1'b1, 1'b0, 14'd1500,  16'd10,    10'd0,    16'd100,   7'd12,  4'b1100},
        // R6 equality 96 sets clear; R7 blocks pe
        '{1'b1, 1'b0, 14'd1500,  16'd10,    10'd0,    16'd96,    7'd12,  4'b1010},
        // R6 one byte over
        '{1'b1, 1'b0, 14'd1500,  16'd10,    10'd0,    16'd97,    7'd12,  4'b1100},
        // R5 busy; R6 zero count with zero margin is in zone
        '{1'b0, 1'b1, 14'd64,    16'd5000,  10'd0,    16'd0,     7'd0,   4'b0010},
        // R9 max fill margin equality: 100+20+1023 = 1143
        '{1'b1, 1'b1, 14'd100,   16'd1143,  10'd1023, 16'd2000,  7'd127, 4'b1100},
        // R9 one short
        '{1'b1, 1'b1, 14'd100,   16'd1142,  10'd1023, 16'd2000,  7'd127, 4'b0001},
        // R9 max clear margin 1016 equality
        '{1'b1, 1'b0, 14'd100,   16'd0,     10'd0,    16'd1016,  7'd127, 4'b1010},
        // R9 1017 just outside
        '{1'b1, 1'b0, 14'd100,   16'd0,     10'd0,    16'd1017,  7'd127, 4'b1100},
        // R3 overhead alone: 0+20 = 20
        '{1'b1, 1'b1, 14'd0,     16'd20,    10'd0,    16'd500,   7'd1,   4'b1100},
        '{1'b1, 1'b1, 14'd0,     16'd19,    10'd0,    16'd500,   7'd1,   4'b0001},
        // R9 max length: 16383+20+1023 = 17426
        '{1'b1, 1'b1, 14'd16383, 16'd17426, 10'd1023, 16'd65535, 7'd127, 4'b1100},
        '{1'b1, 1'b1, 14'd16383, 16'd17425, 10'd1023, 16'd65535, 7'd127, 4'b0001}
    };

    task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {xp,pe,clr,fill} got %b expected %b", req, got, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {xp_start_ok, pe_start_ok, pe_clear, fill_idle};
    endfunction

    task automatic load(input vec_t v);
        port_idle        = v.idle;
        fill_en          = v.fen;
        frame_len        = v.len;
        bytes_to_express = v.btx;
        fill_margin      = v.marg;
        zero_allow_cnt   = v.zac;
        pre_clear_margin = v.pcm;
    endtask

    // Drive at negedge with strobe, sample at next negedge (one register stage).
    task automatic apply(input vec_t v);
        @(negedge clk);
        load(v);
        byte_tick = 1'b1;
        @(negedge clk);
        byte_tick = 1'b0;
    endtask

    initial begin
        // R1: reset with strobe and permissive inputs still gives zeros.
        load(VEC[0]);
        byte_tick = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset", outs(), 4'b0000);
        byte_tick = 1'b0;
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            chk($sformatf("vector %0d (R3-R9 table)", i), outs(), VEC[i].exp);
        end

        // R2: inputs change without strobe; outputs hold.
        apply(VEC[0]);
        chk("R2 load", outs(), 4'b1100);
        @(negedge clk);
        load(VEC[5]);
        @(negedge clk);
        @(negedge clk);
        chk("R2 hold without strobe", outs(), 4'b1100);
        // R5: strobe now takes busy port.
        byte_tick = 1'b1;
        @(negedge clk);
        byte_tick = 1'b0;
        chk("R5 busy after strobe", outs(), 4'b0010);

        // R8: fill off never idles even when countdown is short.
        apply('{1'b1, 1'b0, 14'd64, 16'd0, 10'd5, 16'd500, 7'd1, 4'b1100});
        chk("R8 fill off no idle fill", outs(), 4'b1100);

        // R1: mid-run reset clears.
        apply(VEC[0]);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset", outs(), 4'b0000);
        rst_n = 1'b1;

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule